// File: doc/BRIEF.md
# Translation Look-Aside Buffer with Reference-Bit Replacement

This block is a small, fully associative translation cache that turns a virtual page number into a physical frame number. A lookup is combinational. In the same cycle it reports one of three outcomes: a hit with the frame number, a miss, or a protection fault. The permission result depends on whether the access is a read or a write, and on whether the requester runs in supervisor or user mode. Each entry keeps a valid flag, a recently-used flag, a modified flag and three permission flags: protected, readable and writable.

A miss moves a small controller from `TLB_IDLE` to `TLB_WAIT_FILL`. While in that state it holds a walk request to an external table walker, together with the missed page number. When the walker answers through the fill port, the controller returns to `TLB_IDLE` and the requester retries the access. The fill writes a victim slot, chosen in this order: an empty slot first, then a slot whose recently-used flag is clear, and otherwise the slot under a rotating pointer. In the fill cycle the evicted slot's page, frame and modified flag appear on eviction outputs, so that write-back can be tracked. Software can clear all recently-used flags at once, and a flush empties the whole buffer.

Top module: `tlb_refbit`

## Requirements
- R1: After reset every slot is empty. Any lookup reports a miss, and `walk_req` is low.
- R2: A lookup whose page matches a valid slot, with permissions satisfied, raises `lk_hit` in the same cycle with that slot's frame on `lk_ppn`. A lookup with no valid match raises `lk_miss`. When `lk_valid` is high exactly one of `lk_hit`, `lk_miss` and `lk_fault` is high. When `lk_valid` is low all three are low.
- R3: A matching read needs the slot's readable flag, and a matching write needs its writable flag. Otherwise `lk_fault` is raised instead of `lk_hit`.
- R4: A matching slot with its protected flag set raises `lk_fault` for any access with `lk_super` low. With `lk_super` high, only the read and write flags apply.
- R5: A hit sets the slot's recently-used flag. A pulse on `ref_clear` clears the flag in every slot. A hit in the same cycle as the clear still leaves its own slot marked.
- R6: A write hit sets the slot's modified flag. A fill clears it. The flag is reported on `evict_dirty` when the slot is evicted.
- R7: The fill victim is the lowest-numbered empty slot if one exists. Otherwise it is the lowest-numbered slot whose recently-used flag is clear. Otherwise it is the slot under the rotating pointer. A filled slot starts with its recently-used flag set.
- R8: The rotating pointer starts at slot 0. It advances by one, modulo 8, on every accepted fill, whether or not it chose the victim.
- R9: The states are `TLB_IDLE` and `TLB_WAIT_FILL`. A miss in `TLB_IDLE` moves to `TLB_WAIT_FILL`. From the next cycle `walk_req` is high and `walk_vpn` holds the missed page, unchanged until `fill_valid` is seen. `fill_valid` moves the controller back to `TLB_IDLE`, so `walk_req` is low in the following cycle.
- R10: `flush` empties every slot by the next cycle. A fill in the same cycle as `flush` is dropped, and the pointer does not move.
- R11: In a fill cycle, `evict_valid` is high exactly when the victim slot holds a valid entry. `evict_vpn`, `evict_ppn` and `evict_dirty` then carry that entry's contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | 20 | Virtual page number to translate |
| lk_write | input | 1 | 1 = write access, 0 = read access |
| lk_super | input | 1 | 1 = supervisor mode |
| lk_hit | output | 1 | Translation found and permitted |
| lk_miss | output | 1 | No valid slot matches |
| lk_fault | output | 1 | Match found but access not permitted |
| lk_ppn | output | 16 | Frame number of the matching slot, 0 if none |
| walk_req | output | 1 | Request to the table walker |
| walk_vpn | output | 20 | Page number the walker must fetch |
| fill_valid | input | 1 | Walker delivers a translation |
| fill_vpn | input | 20 | Page number of the fill |
| fill_ppn | input | 16 | Frame number of the fill |
| fill_prot | input | 1 | Protected (supervisor only) flag |
| fill_rd | input | 1 | Readable flag |
| fill_wr | input | 1 | Writable flag |
| ref_clear | input | 1 | Clear all recently-used flags |
| flush | input | 1 | Empty every slot |
| evict_valid | output | 1 | The fill replaces a valid entry |
| evict_vpn | output | 20 | Page of the replaced entry |
| evict_ppn | output | 16 | Frame of the replaced entry |
| evict_dirty | output | 1 | Replaced entry was modified |

## Verification
The lookup outcome, the frame and the eviction outputs are combinational, so they are due in the same cycle as the request. The bench drives inputs on the falling edge and samples them 2 ns later, well before the rising edge. The effects of a cycle land at the next rising edge: flag updates, the fill, a flush and the pointer step. They are therefore observed in the cycle after. The walk request is also due one cycle after the miss. A bench model applies each cycle's updates only after it has compared the current outputs, so every expected value refers to the same cycle as the sample.

// File: rtl/tlb_refbit_pkg.sv
`timescale 1ns/1ps
package tlb_refbit_pkg;
    parameter int VPN_W = 20;
    parameter int PPN_W = 16;

    typedef struct packed {
        logic prot;
        logic rd;
        logic wr;
    } tlb_perm_t;

    typedef struct packed {
        logic             valid;
        logic             refd;
        logic             dirty;
        tlb_perm_t        perm;
        logic [VPN_W-1:0] vpn;
        logic [PPN_W-1:0] ppn;
    } tlb_entry_t;

    typedef enum logic [0:0] {
        TLB_IDLE,
        TLB_WAIT_FILL
    } tlb_state_e;
endpackage

// File: rtl/tlb_refbit_match.sv
`timescale 1ns/1ps
module tlb_refbit_match
    import tlb_refbit_pkg::*;
#(
    parameter int ENTRIES = 8
) (
    input  logic [ENTRIES-1:0]            valid_vec,
    input  logic [ENTRIES-1:0][VPN_W-1:0] vpn_arr,
    input  logic [VPN_W-1:0]              key,
    output logic [ENTRIES-1:0]            match_vec
);
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match_vec[g] = valid_vec[g] && (vpn_arr[g] == key);
    end
endmodule

// File: rtl/tlb_refbit_victim.sv
`timescale 1ns/1ps
module tlb_refbit_victim #(
    parameter int ENTRIES = 8,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic [ENTRIES-1:0] valid_vec,
    input  logic [ENTRIES-1:0] refd_vec,
    input  logic [IDX_W-1:0]   rr_ptr,
    output logic [IDX_W-1:0]   victim
);
    logic             have_free, have_cold;
    logic [IDX_W-1:0] free_idx, cold_idx;

    always_comb begin
        have_free = 1'b0;
        have_cold = 1'b0;
        free_idx  = '0;
        cold_idx  = '0;
        // scan downward so the lowest index wins
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid_vec[i]) begin
                have_free = 1'b1;
                free_idx  = IDX_W'(i);
            end
            if (valid_vec[i] && !refd_vec[i]) begin
                have_cold = 1'b1;
                cold_idx  = IDX_W'(i);
            end
        end
        if (have_free)      victim = free_idx;
        else if (have_cold) victim = cold_idx;
        else                victim = rr_ptr;
    end
endmodule

// File: rtl/tlb_refbit.sv
`timescale 1ns/1ps
module tlb_refbit
    import tlb_refbit_pkg::*;
#(
    parameter int ENTRIES = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_valid,
    input  logic [VPN_W-1:0] lk_vpn,
    input  logic             lk_write,
    input  logic             lk_super,
    output logic             lk_hit,
    output logic             lk_miss,
    output logic             lk_fault,
    output logic [PPN_W-1:0] lk_ppn,
    output logic             walk_req,
    output logic [VPN_W-1:0] walk_vpn,
    input  logic             fill_valid,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PPN_W-1:0] fill_ppn,
    input  logic             fill_prot,
    input  logic             fill_rd,
    input  logic             fill_wr,
    input  logic             ref_clear,
    input  logic             flush,
    output logic             evict_valid,
    output logic [VPN_W-1:0] evict_vpn,
    output logic [PPN_W-1:0] evict_ppn,
    output logic             evict_dirty
);
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    tlb_entry_t                    ent_q [ENTRIES];
    logic [ENTRIES-1:0]            valid_vec, refd_vec, match_vec;
    logic [ENTRIES-1:0][VPN_W-1:0] vpn_arr;
    logic [IDX_W-1:0]              hit_idx, vic_idx, rr_q;
    logic                          any_match, perm_ok, fill_take;
    tlb_entry_t                    hit_ent, vic_ent, new_ent;
    tlb_state_e                    state_q, state_d;
    logic [VPN_W-1:0]              walk_vpn_q;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_flat
        assign valid_vec[g] = ent_q[g].valid;
        assign refd_vec[g]  = ent_q[g].refd;
        assign vpn_arr[g]   = ent_q[g].vpn;
    end

    tlb_refbit_match #(.ENTRIES(ENTRIES)) i_match (
        .valid_vec (valid_vec),
        .vpn_arr   (vpn_arr),
        .key       (lk_vpn),
        .match_vec (match_vec)
    );

    tlb_refbit_victim #(.ENTRIES(ENTRIES)) i_victim (
        .valid_vec (valid_vec),
        .refd_vec  (refd_vec),
        .rr_ptr    (rr_q),
        .victim    (vic_idx)
    );

    // lookup path
    always_comb begin
        hit_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match_vec[i]) hit_idx = IDX_W'(i);
        end
    end

    assign any_match = |match_vec;
    assign hit_ent   = ent_q[hit_idx];
    assign perm_ok   = (!hit_ent.perm.prot || lk_super) &&
                       (lk_write ? hit_ent.perm.wr : hit_ent.perm.rd);
    assign lk_hit    = lk_valid && any_match && perm_ok;
    assign lk_fault  = lk_valid && any_match && !perm_ok;
    assign lk_miss   = lk_valid && !any_match;
    assign lk_ppn    = any_match ? hit_ent.ppn : '0;

    // fill and eviction path
    assign fill_take   = fill_valid && !flush;
    assign vic_ent     = ent_q[vic_idx];
    assign evict_valid = fill_take && vic_ent.valid;
    assign evict_vpn   = vic_ent.vpn;
    assign evict_ppn   = vic_ent.ppn;
    assign evict_dirty = evict_valid && vic_ent.dirty;

    always_comb begin
        new_ent           = '0;
        new_ent.valid     = 1'b1;
        new_ent.refd      = 1'b1;
        new_ent.perm.prot = fill_prot;
        new_ent.perm.rd   = fill_rd;
        new_ent.perm.wr   = fill_wr;
        new_ent.vpn       = fill_vpn;
        new_ent.ppn       = fill_ppn;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) ent_q[i] <= '0;
            rr_q <= '0;
        end else begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (flush) begin
                    ent_q[i].valid <= 1'b0;
                    ent_q[i].refd  <= 1'b0;
                    ent_q[i].dirty <= 1'b0;
                end else begin
                    if (ref_clear) ent_q[i].refd <= 1'b0;
                    if (lk_hit && hit_idx == IDX_W'(i)) begin
                        ent_q[i].refd <= 1'b1;
                        if (lk_write) ent_q[i].dirty <= 1'b1;
                    end
                    if (fill_take && vic_idx == IDX_W'(i)) ent_q[i] <= new_ent;
                end
            end
            if (fill_take) begin
                rr_q <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
            end
        end
    end

    // walk controller: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= TLB_IDLE;
            walk_vpn_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == TLB_IDLE && lk_miss) walk_vpn_q <= lk_vpn;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TLB_IDLE:      if (lk_miss)    state_d = TLB_WAIT_FILL;
            TLB_WAIT_FILL: if (fill_valid) state_d = TLB_IDLE;
            default:                       state_d = TLB_IDLE;
        endcase
    end

    // walk controller: outputs
    always_comb begin
        walk_req = 1'b0;
        walk_vpn = walk_vpn_q;
        unique case (state_q)
            TLB_IDLE:      walk_req = 1'b0;
            TLB_WAIT_FILL: walk_req = 1'b1;
            default:       walk_req = 1'b0;
        endcase
    end
endmodule

// File: rtl/tlb_refbit_chk.sv
`timescale 1ns/1ps
module tlb_refbit_chk
    import tlb_refbit_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             lk_valid,
    input logic [VPN_W-1:0] lk_vpn,
    input logic             lk_hit,
    input logic             lk_miss,
    input logic             lk_fault,
    input logic             walk_req,
    input logic [VPN_W-1:0] walk_vpn,
    input logic             fill_valid,
    input logic [VPN_W-1:0] fill_vpn,
    input logic             flush,
    input logic             evict_valid
);
    p_one_outcome_r2: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |-> $countones({lk_hit, lk_miss, lk_fault}) == 1);

    p_quiet_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |-> !(lk_hit || lk_miss || lk_fault));

    p_walk_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!walk_req && lk_miss) |=> (walk_req && walk_vpn == $past(lk_vpn)));

    p_walk_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_req && !fill_valid) |=> (walk_req && $stable(walk_vpn)));

    p_walk_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_req && fill_valid) |=> !walk_req);

    p_flush_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !(lk_hit || lk_fault) && !evict_valid);

    p_fill_visible_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && !flush) |=>
            (!(lk_valid && lk_vpn == $past(fill_vpn)) || !lk_miss));

    p_evict_in_fill_r11: assert property (@(posedge clk) disable iff (!rst_n)
        evict_valid |-> fill_valid);
endmodule

bind tlb_refbit tlb_refbit_chk i_chk (.*);

// File: tb/test_tlb_refbit.sv
`timescale 1ns/1ps
module test_tlb_refbit;
    import tlb_refbit_pkg::*;

    localparam int N = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             lk_valid = 1'b0, lk_write = 1'b0, lk_super = 1'b0;
    logic [VPN_W-1:0] lk_vpn = '0;
    logic             lk_hit, lk_miss, lk_fault;
    logic [PPN_W-1:0] lk_ppn;
    logic             walk_req;
    logic [VPN_W-1:0] walk_vpn;
    logic             fill_valid = 1'b0, fill_prot = 1'b0, fill_rd = 1'b0, fill_wr = 1'b0;
    logic [VPN_W-1:0] fill_vpn = '0;
    logic [PPN_W-1:0] fill_ppn = '0;
    logic             ref_clear = 1'b0, flush = 1'b0;
    logic             evict_valid, evict_dirty;
    logic [VPN_W-1:0] evict_vpn;
    logic [PPN_W-1:0] evict_ppn;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    // reference model
    bit               m_valid[N], m_ref[N], m_dirty[N], m_prot[N], m_rd[N], m_wr[N];
    logic [VPN_W-1:0] m_vpn[N];
    logic [PPN_W-1:0] m_ppn[N];
    int               m_rr = 0;
    bit               m_wait = 1'b0;
    logic [VPN_W-1:0] m_wvpn = '0;

    bit               last_ev;
    logic [VPN_W-1:0] last_ev_vpn;
    bit               last_ev_dirty;

    always #10 clk = ~clk;

    tlb_refbit i_tlb_refbit (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp,
                         input string ctx);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, ctx, act, exp);
        end
    endtask

    function automatic int model_match(input logic [VPN_W-1:0] v);
        for (int i = 0; i < N; i++) if (m_valid[i] && m_vpn[i] == v) return i;
        return -1;
    endfunction

    function automatic int model_victim();
        for (int i = 0; i < N; i++) if (!m_valid[i]) return i;
        for (int i = 0; i < N; i++) if (!m_ref[i]) return i;
        return m_rr;
    endfunction

    function automatic bit model_allows(input int mi);
        return (!m_prot[mi] || lk_super) && (lk_write ? m_wr[mi] : m_rd[mi]);
    endfunction

    task automatic tick(input string ctx);
        int mi, vi;
        bit ok, ev;
        logic [2:0] expv;
        #2;
        mi = model_match(lk_vpn);
        ok = (mi >= 0) && model_allows(mi);
        if (!lk_valid)    expv = 3'b000;
        else if (mi < 0)  expv = 3'b010;
        else if (ok)      expv = 3'b100;
        else              expv = 3'b001;
        check("R2", {lk_hit, lk_miss, lk_fault}, {29'd0, expv}, ctx);
        if (lk_valid && mi >= 0) check("R2", lk_ppn, m_ppn[mi], ctx);
        check("R9", walk_req, m_wait, ctx);
        if (m_wait) check("R9", walk_vpn, m_wvpn, ctx);
        vi = model_victim();
        ev = fill_valid && !flush && m_valid[vi];
        check("R11", evict_valid, ev, ctx);
        if (ev) begin
            check("R11", evict_vpn, m_vpn[vi], ctx);
            check("R11", evict_ppn, m_ppn[vi], ctx);
            check("R11", evict_dirty, m_dirty[vi], ctx);
        end
        last_ev = evict_valid;
        last_ev_vpn = evict_vpn;
        last_ev_dirty = evict_dirty;
        @(posedge clk);
        if (flush) begin
            for (int i = 0; i < N; i++) begin
                m_valid[i] = 0; m_ref[i] = 0; m_dirty[i] = 0;
            end
        end else begin
            if (ref_clear) for (int i = 0; i < N; i++) m_ref[i] = 0;
            if (lk_valid && ok) begin
                m_ref[mi] = 1;
                if (lk_write) m_dirty[mi] = 1;
            end
            if (fill_valid) begin
                m_valid[vi] = 1; m_ref[vi] = 1; m_dirty[vi] = 0;
                m_prot[vi] = fill_prot; m_rd[vi] = fill_rd; m_wr[vi] = fill_wr;
                m_vpn[vi] = fill_vpn; m_ppn[vi] = fill_ppn;
                m_rr = (m_rr + 1) % N;
            end
        end
        if (!m_wait) begin
            if (lk_valid && mi < 0) begin
                m_wait = 1; m_wvpn = lk_vpn;
            end
        end else if (fill_valid) begin
            m_wait = 0;
        end
        @(negedge clk);
    endtask

    task automatic idle_in();
        lk_valid = 0; lk_write = 0; lk_super = 0; fill_valid = 0;
        fill_prot = 0; fill_rd = 0; fill_wr = 0; ref_clear = 0; flush = 0;
    endtask

    task automatic do_fill(input int v, input int p, input bit pr, input bit r, input bit w,
                           input string ctx);
        idle_in();
        fill_valid = 1; fill_vpn = VPN_W'(v); fill_ppn = PPN_W'(p);
        fill_prot = pr; fill_rd = r; fill_wr = w;
        tick(ctx);
        idle_in();
    endtask

    task automatic do_look(input int v, input bit w, input bit s, input string ctx);
        idle_in();
        lk_valid = 1; lk_vpn = VPN_W'(v); lk_write = w; lk_super = s;
        #2;
        tick(ctx);
        idle_in();
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240521));
        for (int i = 0; i < N; i++) begin
            m_valid[i] = 0; m_ref[i] = 0; m_dirty[i] = 0;
            m_prot[i] = 0; m_rd[i] = 0; m_wr[i] = 0; m_vpn[i] = '0; m_ppn[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        lk_valid = 1; lk_vpn = 20'd3;
        #2;
        check("R1", {lk_hit, lk_miss, lk_fault}, 32'b010, "empty after reset");
        check("R1", walk_req, 1'b0, "no walk after reset");
        tick("R1 first miss");
        idle_in();
        // R9: walk request the cycle after the miss
        #2;
        check("R9", walk_req, 1'b1, "walk raised");
        check("R9", walk_vpn, 20'd3, "walk page");

        // R7: empty slots fill in order 0..7
        for (int i = 0; i < N; i++) begin
            do_fill(i, 16'h100 + i, 0, 1, 1, "R7 fill empty");
            check("R7", last_ev, 1'b0, "no eviction into empty slot");
        end
        #2;
        check("R9", walk_req, 1'b0, "walk dropped after fill");
        do_look(3, 0, 0, "R2 hit");

        // R8: all slots marked -> pointer wrapped back to slot 0
        do_fill(8, 16'h108, 0, 1, 1, "R8 rotate");
        check("R8", last_ev, 1'b1, "pointer victim valid");
        check("R8", last_ev_vpn, 20'd0, "pointer victim is slot 0");

        // R5/R6: clear flags, then touch slots 1 and 2
        idle_in(); ref_clear = 1; tick("R5 clear"); idle_in();
        do_look(2, 0, 0, "R5 read hit");
        do_look(1, 1, 0, "R6 write hit");
        do_fill(9, 16'h109, 0, 1, 1, "R7 cold slot");
        check("R7", last_ev_vpn, 20'd8, "lowest cold slot 0");
        do_fill(10, 16'h10a, 0, 1, 1, "R5 skip used");
        check("R5", last_ev_vpn, 20'd3, "used slots 1,2 skipped");
        idle_in(); ref_clear = 1; tick("R5 clear again"); idle_in();
        do_fill(11, 16'h10b, 0, 1, 1, "R6 clean evict");
        check("R6", last_ev_dirty, 1'b0, "slot 0 was clean");
        do_fill(12, 16'h10c, 0, 1, 1, "R6 dirty evict");
        check("R6", last_ev_vpn, 20'd1, "slot 1 evicted");
        check("R6", last_ev_dirty, 1'b1, "write hit made slot 1 dirty");

        // R10: flush
        idle_in(); flush = 1; tick("R10 flush"); idle_in();
        lk_valid = 1; lk_vpn = 20'd12;
        #2;
        check("R10", {lk_hit, lk_miss, lk_fault}, 32'b010, "miss after flush");
        tick("R10 miss"); idle_in();
        do_fill(20, 16'h220, 0, 1, 0, "R10 refill");
        check("R10", last_ev, 1'b0, "no eviction after flush");

        // R3/R4: permissions
        do_fill(21, 16'h221, 1, 1, 1, "R4 fill prot");
        lk_valid = 1; lk_vpn = 20'd20; lk_write = 1;
        #2;
        check("R3", {lk_hit, lk_fault}, 32'b01, "write to read-only faults");
        tick("R3 w"); idle_in();
        lk_valid = 1; lk_vpn = 20'd20;
        #2;
        check("R3", {lk_hit, lk_fault}, 32'b10, "read of readable hits");
        check("R2", lk_ppn, 16'h220, "frame");
        tick("R3 r"); idle_in();
        lk_valid = 1; lk_vpn = 20'd21; lk_super = 0;
        #2;
        check("R4", {lk_hit, lk_fault}, 32'b01, "user on protected faults");
        tick("R4 u"); idle_in();
        lk_valid = 1; lk_vpn = 20'd21; lk_super = 1; lk_write = 1;
        #2;
        check("R4", {lk_hit, lk_fault}, 32'b10, "supervisor on protected hits");
        tick("R4 s"); idle_in();

        // random mix against the model
        for (int k = 0; k < 3000; k++) begin
            int v;
            idle_in();
            lk_valid = ($urandom % 4) != 0;
            lk_vpn = VPN_W'($urandom % 16);
            lk_write = $urandom % 2;
            lk_super = $urandom % 2;
            if (($urandom % 10) < 3) begin
                v = $urandom % 16;
                if (model_match(VPN_W'(v)) < 0) begin
                    fill_valid = 1; fill_vpn = VPN_W'(v); fill_ppn = PPN_W'($urandom);
                    fill_prot = $urandom % 2; fill_rd = $urandom % 2; fill_wr = $urandom % 2;
                end
            end
            ref_clear = ($urandom % 20) == 0;
            flush = ($urandom % 60) == 0;
            tick("random");
        end
        idle_in();

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule